// File: doc/BRIEF.md
# Category-Coalescing First-Fit Slot Allocator

This block hands out slot numbers to a row of lanes in one combinational step. Each lane offers an enable bit and a small category code. The lanes are walked in a fixed priority order, which a parameter sets to either lowest index first or highest index first. In that order, the first enabled lane of each category becomes that category's leader. Leaders are numbered 0, 1, 2 and so on, in the order they are found.

Every lane then reports the slot of the earliest leader of its own category that sits at or before it in priority order. This holds whether or not the lane itself is enabled, so a disabled lane that follows a leader of its category inherits that leader's slot. A lane with no such leader reports 0. Each slot is zero-extended into the lane's output field.

Leadership, the slot numbering and the final gather are built from log-depth prefix networks, not from a lane-by-lane ripple chain. The block has no clock and no state.

Top module: `category_first_fit_alloc`

## Requirements
- R1: A lane is a leader exactly when it is enabled and no enabled lane earlier in priority order carries the same category. Each category therefore has at most one leader, and it has one whenever any of its lanes is enabled.
- R2: Leaders receive slot numbers 0, 1, 2 and so on, in priority order. A leader's own output field holds its own slot.
- R3: Every lane, enabled or not, outputs the slot of the earliest leader at or before it in priority order whose category equals the lane's category.
- R4: A lane with no same-category leader at or before it in priority order outputs 0. This includes every lane when no lane is enabled.
- R5: A lane's own enable plays no part in its output. A disabled lane placed after a same-category leader outputs that leader's slot.
- R6: With MSB_FIRST=0, lane 0 comes first in priority order. With MSB_FIRST=1, lane N_LANES-1 comes first, and the result equals the MSB_FIRST=0 result on the lane-reversed inputs.
- R7: Lane k's category is lane_cat[k*CAT_W +: CAT_W] and its result is lane_slot[k*FIELD_W +: FIELD_W]. The slot, which is clog2(N_LANES) bits wide, is zero-extended into the field, so the field bits above the slot width are 0. FIELD_W must be at least the slot width.
- R8: The outputs are a purely combinational function of lane_en and lane_cat. They follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lane_en | input | N_LANES | Per-lane enable; bit k belongs to lane k |
| lane_cat | input | N_LANES*CAT_W | Per-lane category codes, packed with lane k in slice k |
| lane_slot | output | N_LANES*FIELD_W | Per-lane zero-extended slot results, packed with lane k in slice k |

## Verification
The assertions check structural properties on every input change:
- each category has at most one leader, and it has one whenever any lane of that category is enabled;
- the slot numbers step by exactly one past each leader;
- the first lane in priority order always reports 0;
- an enabled lane and any later lane of the same category always report the same slot.

These properties cannot show that the slots have the right absolute values, that the direction parameter reverses the order, that the upper field bits are zero, or that a disabled lane inherits a slot rather than reporting 0. Those are shown only by the bench, which compares both direction variants against hand-worked vectors, an independent loop model over every enable pattern, and random category mixes.

// File: rtl/ffalloc_pkg.sv
package ffalloc_pkg;

  // Width of a slot number for a given lane count (slots span 0..lanes-1).
  function automatic int slot_bits(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

  // Width of an inclusive leader count (spans 0..lanes).
  function automatic int count_bits(input int lanes);
    return $clog2(lanes + 1);
  endfunction

  // Number of doubling stages in a prefix network over `lanes` entries.
  function automatic int scan_levels(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 0;
  endfunction

endpackage

// File: rtl/ffalloc_prefix_or.sv
// Inclusive prefix OR, built as a doubling (log-depth) network.
module ffalloc_prefix_or #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bits_in,
  output logic [WIDTH-1:0] bits_out
);
  import ffalloc_pkg::*;

  localparam int LEVELS = scan_levels(WIDTH);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    logic [WIDTH-1:0] prv;
    logic [WIDTH-1:0] nxt;

    if (l == 0) begin : g_head
      assign prv = bits_in;
    end else begin : g_link
      assign prv = g_lvl[l-1].nxt;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= DIST) begin : g_join
        assign nxt[i] = prv[i] | prv[i-DIST];
      end else begin : g_keep
        assign nxt[i] = prv[i];
      end
    end
  end

  if (LEVELS == 0) begin : g_flat
    assign bits_out = bits_in;
  end else begin : g_tail
    assign bits_out = g_lvl[LEVELS-1].nxt;
  end

endmodule

// File: rtl/ffalloc_leader_scan.sv
// Finds, per category, the first enabled lane in priority order (lane 0 first).
module ffalloc_leader_scan #(
  parameter int N_LANES = 8,
  parameter int CAT_W   = 2
) (
  input  logic [N_LANES-1:0]       en,
  input  logic [N_LANES*CAT_W-1:0] cat,
  output logic [N_LANES-1:0]       leader
);
  localparam int N_CAT = 1 << CAT_W;

  logic [N_CAT*N_LANES-1:0] per_cat;

  for (genvar c = 0; c < N_CAT; c++) begin : g_cat
    logic [N_LANES-1:0] hit;
    logic [N_LANES-1:0] seen;

    for (genvar i = 0; i < N_LANES; i++) begin : g_hit
      assign hit[i] = en[i] && (cat[i*CAT_W +: CAT_W] == CAT_W'(c));
    end

    ffalloc_prefix_or #(.WIDTH(N_LANES)) u_seen (
      .bits_in  (hit),
      .bits_out (seen)
    );

    // The leader sits where the running "category seen" flag first rises.
    for (genvar i = 0; i < N_LANES; i++) begin : g_rise
      if (i == 0) begin : g_first
        assign per_cat[c*N_LANES] = seen[0];
      end else begin : g_rest
        assign per_cat[c*N_LANES + i] = seen[i] & ~seen[i-1];
      end
    end

    // One leader per category, present whenever that category is enabled.
    always_comb begin
      if (!$isunknown({en, cat})) begin
        assert_one_leader_R1: assert ($onehot0(per_cat[c*N_LANES +: N_LANES]) &&
                                      ((|hit) == (|per_cat[c*N_LANES +: N_LANES])))
          else $error("category %0d leader set malformed", c);
      end
    end
  end

  always_comb begin
    leader = '0;
    for (int c = 0; c < N_CAT; c++) leader |= per_cat[c*N_LANES +: N_LANES];
  end

endmodule

// File: rtl/ffalloc_slot_count.sv
// Numbers the leaders: slot[i] = leaders strictly before lane i (log-depth sum).
module ffalloc_slot_count #(
  parameter int N_LANES = 8,
  parameter int SLOT_W  = 3
) (
  input  logic [N_LANES-1:0]        leader,
  output logic [N_LANES*SLOT_W-1:0] slot
);
  import ffalloc_pkg::*;

  localparam int CNT_W  = count_bits(N_LANES);
  localparam int LEVELS = scan_levels(N_LANES);

  logic [N_LANES*CNT_W-1:0] base;
  logic [N_LANES*CNT_W-1:0] incl;

  for (genvar i = 0; i < N_LANES; i++) begin : g_base
    assign base[i*CNT_W +: CNT_W] = CNT_W'(leader[i]);
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    logic [N_LANES*CNT_W-1:0] prv;
    logic [N_LANES*CNT_W-1:0] nxt;

    if (l == 0) begin : g_head
      assign prv = base;
    end else begin : g_link
      assign prv = g_lvl[l-1].nxt;
    end

    for (genvar i = 0; i < N_LANES; i++) begin : g_sum
      if (i >= DIST) begin : g_add
        assign nxt[i*CNT_W +: CNT_W] = prv[i*CNT_W +: CNT_W] + prv[(i-DIST)*CNT_W +: CNT_W];
      end else begin : g_keep
        assign nxt[i*CNT_W +: CNT_W] = prv[i*CNT_W +: CNT_W];
      end
    end
  end

  if (LEVELS == 0) begin : g_flat
    assign incl = base;
  end else begin : g_tail
    assign incl = g_lvl[LEVELS-1].nxt;
  end

  // Exclusive count = inclusive count minus the lane's own leader bit.
  for (genvar i = 0; i < N_LANES; i++) begin : g_excl
    assign slot[i*SLOT_W +: SLOT_W] =
      SLOT_W'(incl[i*CNT_W +: CNT_W] - CNT_W'(leader[i]));
  end

  // Numbering starts at zero and advances by one past every leader.
  always_comb begin
    if (!$isunknown(leader)) begin
      assert_slot_start_R2: assert (slot[SLOT_W-1:0] == '0)
        else $error("first slot number is not zero");
      for (int i = 0; i < N_LANES - 1; i++) begin
        assert_slot_step_R2: assert (slot[(i+1)*SLOT_W +: SLOT_W] ==
                                     SLOT_W'(slot[i*SLOT_W +: SLOT_W] + SLOT_W'(leader[i])))
          else $error("slot numbering skips at lane %0d", i);
      end
    end
  end

endmodule

// File: rtl/ffalloc_lane_gather.sv
// Each lane ORs together the slots of same-category leaders at or before it.
module ffalloc_lane_gather #(
  parameter int N_LANES = 8,
  parameter int CAT_W   = 2,
  parameter int SLOT_W  = 3
) (
  input  logic [N_LANES-1:0]        leader,
  input  logic [N_LANES*CAT_W-1:0]  cat,
  input  logic [N_LANES*SLOT_W-1:0] slot,
  output logic [N_LANES*SLOT_W-1:0] lane_out
);

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [SLOT_W-1:0] acc;

    always_comb begin
      acc = '0;
      for (int i = 0; i <= k; i++) begin
        if (leader[i] && (cat[i*CAT_W +: CAT_W] == cat[k*CAT_W +: CAT_W]))
          acc |= slot[i*SLOT_W +: SLOT_W];
      end
    end

    assign lane_out[k*SLOT_W +: SLOT_W] = acc;
  end

endmodule

// File: rtl/category_first_fit_alloc.sv
module category_first_fit_alloc #(
  parameter int N_LANES   = 8,
  parameter int CAT_W     = 2,
  parameter int FIELD_W   = 4,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic [N_LANES-1:0]         lane_en,
  input  logic [N_LANES*CAT_W-1:0]   lane_cat,
  output logic [N_LANES*FIELD_W-1:0] lane_slot
);
  import ffalloc_pkg::*;

  localparam int SLOT_W = slot_bits(N_LANES);

  // All internal vectors are in priority order: position 0 is scanned first.
  logic [N_LANES-1:0]        en_p;
  logic [N_LANES*CAT_W-1:0]  cat_p;
  logic [N_LANES-1:0]        leader_p;
  logic [N_LANES*SLOT_W-1:0] slot_p;
  logic [N_LANES*SLOT_W-1:0] res_p;

  for (genvar i = 0; i < N_LANES; i++) begin : g_order
    localparam int SRC = MSB_FIRST ? (N_LANES - 1 - i) : i;
    assign en_p[i]                        = lane_en[SRC];
    assign cat_p[i*CAT_W +: CAT_W]        = lane_cat[SRC*CAT_W +: CAT_W];
    assign lane_slot[SRC*FIELD_W +: FIELD_W] = FIELD_W'(res_p[i*SLOT_W +: SLOT_W]);
  end

  ffalloc_leader_scan #(.N_LANES(N_LANES), .CAT_W(CAT_W)) u_scan (
    .en     (en_p),
    .cat    (cat_p),
    .leader (leader_p)
  );

  ffalloc_slot_count #(.N_LANES(N_LANES), .SLOT_W(SLOT_W)) u_count (
    .leader (leader_p),
    .slot   (slot_p)
  );

  ffalloc_lane_gather #(.N_LANES(N_LANES), .CAT_W(CAT_W), .SLOT_W(SLOT_W)) u_gather (
    .leader   (leader_p),
    .cat      (cat_p),
    .slot     (slot_p),
    .lane_out (res_p)
  );

  always_comb begin
    if (!$isunknown({lane_en, lane_cat})) begin
      // The first lane scanned has nothing before it: slot 0 either way.
      assert_first_lane_zero_R4: assert (res_p[SLOT_W-1:0] == '0)
        else $error("first priority lane reports a nonzero slot");
      // An enabled lane and any later lane of its category share one slot,
      // whatever the later lane's enable.
      for (int i = 0; i < N_LANES; i++) begin
        for (int j = i + 1; j < N_LANES; j++) begin
          if (en_p[i] && (cat_p[i*CAT_W +: CAT_W] == cat_p[j*CAT_W +: CAT_W])) begin
            assert_same_cat_agree_R5: assert (res_p[i*SLOT_W +: SLOT_W] == res_p[j*SLOT_W +: SLOT_W])
              else $error("positions %0d and %0d disagree", i, j);
          end
        end
      end
    end
  end

endmodule

// File: tb/tb_category_first_fit_alloc.sv
module tb_category_first_fit_alloc;
  localparam int N     = 8;
  localparam int C     = 2;
  localparam int FW    = 4;
  localparam int OW    = N * FW;
  localparam int NCAT  = 1 << C;
  localparam int NROWS = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [N-1:0]  en    = '0;
  logic [N*C-1:0] cat  = '0;
  logic [OW-1:0] out_lsb;
  logic [OW-1:0] out_msb;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  category_first_fit_alloc #(.N_LANES(N), .CAT_W(C), .FIELD_W(FW), .MSB_FIRST(1'b0)) dut (
    .lane_en (en), .lane_cat (cat), .lane_slot (out_lsb)
  );

  category_first_fit_alloc #(.N_LANES(N), .CAT_W(C), .FIELD_W(FW), .MSB_FIRST(1'b1)) dut_msb (
    .lane_en (en), .lane_cat (cat), .lane_slot (out_msb)
  );

  // Row layout: {enable, categories, expected lowest-first, expected highest-first}.
  localparam logic [87:0] TBL [NROWS] = '{
    {8'h00, 16'h1B6C, 32'h0000_0000, 32'h0000_0000},
    {8'hFF, 16'h0000, 32'h0000_0000, 32'h0000_0000},
    {8'hFF, 16'hE4E4, 32'h3210_3210, 32'h0123_0123},
    {8'h06, 16'hAAEE, 32'h1111_0100, 32'h0000_0010},
    {8'hF0, 16'hE4E4, 32'h3210_0000, 32'h0123_0123}
  };

  // Behavioural loop model written from the requirements.
  function automatic logic [OW-1:0] model(input logic [N-1:0] e, input logic [N*C-1:0] c,
                                          input bit msb);
    logic [OW-1:0] r;
    int lead_slot [NCAT];
    bit have [NCAT];
    int nxt;
    int lane;
    int k;
    r   = '0;
    nxt = 0;
    for (int q = 0; q < NCAT; q++) begin
      lead_slot[q] = 0;
      have[q]      = 1'b0;
    end
    for (int p = 0; p < N; p++) begin
      lane = msb ? (N - 1 - p) : p;
      k    = int'(c[lane*C +: C]);
      if (e[lane] && !have[k]) begin
        have[k]      = 1'b1;
        lead_slot[k] = nxt;
        nxt++;
      end
      if (have[k]) r[lane*FW +: FW] = FW'(lead_slot[k]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] got, input logic [OW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] e, input logic [N*C-1:0] c);
    @(negedge clk);
    en  = e;
    cat = c;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]   re;
    logic [N*C-1:0] rc;

    // Reset window: nothing enabled, every lane reports 0 (R4).
    repeat (2) @(negedge clk);
    #2;
    if (!rst_n) check("R4 reset all-zero lsb", out_lsb, '0);
    if (!rst_n) check("R4 reset all-zero msb", out_msb, '0);
    rst_n = 1'b1;

    // Hand-worked rows: leaders (R1), numbering (R2), inheritance (R3),
    // no leader gives 0 (R4), disabled inheritance (R5), direction (R6).
    for (int r = 0; r < NROWS; r++) begin
      drive(TBL[r][87:80], TBL[r][79:64]);
      check($sformatf("R1/R2/R3/R4/R5 table row %0d lsb", r), out_lsb, TBL[r][63:32]);
      check($sformatf("R6 table row %0d msb", r), out_msb, TBL[r][31:0]);
    end

    // R5: lanes 2..7 disabled, category 1, follow the leader in lane 1 (slot 1).
    drive(8'h03, 16'h5554);
    check("R5 disabled lanes inherit slot", out_lsb, 32'h1111_1110);

    // R8: outputs follow an input change with no clock edge in between.
    @(negedge clk);
    en  = 8'hFF;
    cat = 16'hE4E4;
    #1;
    en  = 8'h06;
    cat = 16'hAAEE;
    #1;
    check("R8 combinational update", out_lsb, 32'h1111_0100);

    // R1/R3: every enable pattern under two fixed category mixes.
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < (1 << N); e++) begin
        rc = (m == 0) ? 16'hE4E4 : 16'h5A0F;
        drive(N'(e), rc);
        check($sformatf("R1 R3 sweep en=%02h lsb", e), out_lsb, model(N'(e), rc, 1'b0));
        check($sformatf("R6 sweep en=%02h msb", e), out_msb, model(N'(e), rc, 1'b1));
      end
    end

    // R3/R6/R7: random enables and categories.
    for (int t = 0; t < 300; t++) begin
      re = N'($urandom);
      rc = (N*C)'($urandom);
      drive(re, rc);
      check("R3 random lsb", out_lsb, model(re, rc, 1'b0));
      check("R6 random msb", out_msb, model(re, rc, 1'b1));
      check("R7 upper field bits zero", out_lsb & 32'h8888_8888, '0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule